// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block turns a parallel word into a serial frame on one output line. An 8-bit mode byte, written over a simple write strobe and data bus, sets the frame shape. It selects the data length through a 2-bit mode, a parity option, one or two stop bits, and synchronous or asynchronous transfer. It also gates the clock and data output pins. The baud rate comes from outside as a one-cycle tick, and each tick moves the line on by one bit.

A client places a word on `tx_data` and pulses `tx_start` while `tx_busy` is low. The frame is a low start bit, then the payload least significant bit first, then high stop bits. `tx_done` pulses for one cycle at the end of the frame. The frame shape is captured when a frame is accepted, so rewriting the mode byte during a frame reshapes only the frames that follow. In synchronous mode a shift clock on `sclk_out` goes low for one system clock each time a new bit appears on the line. A receiver can sample on the rising edge that follows.

Top module: `sft_top`

## Requirements
- R1: After synchronous reset `reg_rdata` is 8'h00, `txd_out` is 1, `sclk_out` is 1, and `tx_busy`, `tx_done`, `txd_oe` and `sclk_oe` are 0.
- R2: A cycle with `reg_we` high loads `reg_wdata` into the mode byte, which is readable on `reg_rdata` from the next cycle. Bit 3 is unused and always reads 0. The field layout is: bit 7 parity enable, bit 6 two stop bits, bits 5:4 mode, bit 2 synchronous select, bit 1 clock output enable, bit 0 data output enable.
- R3: On the clock edge that accepts a start, `txd_out` goes low (the start bit). Each later `baud_tick` puts the next frame bit on `txd_out` on the following edge. Payload bits go least significant first, and the line idles high.
- R4: With parity off, the payload is 7 data bits in mode 0, 8 in mode 1 and 9 in mode 3, taken from `tx_data[0]` upward.
- R5: With parity on in modes 0, 1 and 3, the last payload position carries a parity bit in place of the last data bit (6, 7 or 8 data bits). When `par_odd` is 0 the data bits plus the parity bit hold an even number of ones; when it is 1 they hold an odd number.
- R6: Mode 2 sends `tx_data[7:0]` followed by `tx_bit9` as a ninth bit, whatever the parity enable bit holds.
- R7: One high stop bit follows the payload when bit 6 is 0, and two when it is 1.
- R8: `tx_busy` rises on the accepting edge. On the edge of the tick that ends the last stop bit, `tx_busy` falls and `tx_done` is high for exactly that one cycle.
- R9: A `tx_start` while `tx_busy` is high is ignored, including one in the cycle of the final tick. The frame in progress and the line are unchanged, and no new frame begins.
- R10: A frame uses the mode byte held when it is accepted, including a write in that same cycle, which waits for the next frame. Writes during a frame do not alter it.
- R11: `txd_oe` follows mode bit 0 and `sclk_oe` follows mode bit 1, changing one cycle after the write.
- R12: In a frame accepted with synchronous select set, `sclk_out` is 0 in the cycle after each bit change, start bit included, and 1 otherwise. In asynchronous frames and when idle it stays 1.
- R13: A `baud_tick` while idle has no effect. A tick in the same cycle as an accepted start does not shorten the start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Mode byte write strobe |
| reg_wdata | input | 8 | Mode byte write data |
| reg_rdata | output | 8 | Mode byte read-back |
| baud_tick | input | 1 | One-cycle bit-rate tick |
| tx_start | input | 1 | Start request, taken only when idle |
| tx_data | input | 9 | Word to send, bit 0 first |
| tx_bit9 | input | 1 | Ninth bit for mode 2 |
| par_odd | input | 1 | 1 selects odd parity, 0 even |
| tx_busy | output | 1 | Frame in progress |
| tx_done | output | 1 | One-cycle end-of-frame pulse |
| txd_out | output | 1 | Serial line value |
| txd_oe | output | 1 | Serial line drive enable |
| sclk_out | output | 1 | Synchronous shift clock |
| sclk_oe | output | 1 | Shift clock drive enable |

## Verification
Several inputs can land in the same cycle as the start of a frame or the end of one. The bench raises `baud_tick` together with an accepted `tx_start`, writes the mode byte in the start cycle, and raises `tx_start` on the final tick. Each case is judged by comparing every bit time of the line, `tx_busy` and `tx_done` against a frame computed in the bench from the mode byte that R10 says applies. A restart that should be ignored is also confirmed by the line staying high and `tx_busy` staying low afterwards.

// File: rtl/sft_pkg.sv
package sft_pkg;
  localparam int CFG_W   = 8;
  localparam int PAY_MAX = 9;
  localparam int FRAME_W = PAY_MAX + 3;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  typedef struct packed {
    logic       par_en;
    logic       stop2;
    logic [1:0] mode;
    logic       rsvd;
    logic       sync_en;
    logic       clk_oe;
    logic       dat_oe;
  } sft_cfg_t;
endpackage

// File: rtl/sft_cfg_reg.sv
module sft_cfg_reg
  import sft_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output sft_cfg_t         cfg
);
  localparam logic [CFG_W-1:0] KEEP_MASK = 8'hF7;

  always_ff @(posedge clk) begin
    if (rst) cfg <= '0;
    else if (we) cfg <= sft_cfg_t'(wdata & KEEP_MASK);
  end
endmodule

// File: rtl/sft_frame_build.sv
module sft_frame_build
  import sft_pkg::*;
#(
  parameter int DATA_W = PAY_MAX,
  parameter int FW     = DATA_W + 3,
  parameter int CW     = $clog2(FW + 1)
) (
  input  sft_cfg_t          cfg,
  input  logic [DATA_W-1:0] data,
  input  logic              bit9,
  input  logic              par_odd,
  output logic [FW-1:0]     frame,
  output logic [CW-1:0]     nbits
);
  logic [CW-1:0] base_len;
  logic [CW-1:0] nd;
  logic [CW-1:0] plen;
  logic          use_par;
  logic          extra;
  logic          par;
  logic [DATA_W-1:0] payload;

  always_comb begin
    case (cfg.mode)
      2'd0:    base_len = CW'(7);
      2'd1:    base_len = CW'(8);
      2'd2:    base_len = CW'(8);
      default: base_len = CW'(9);
    endcase
    use_par = cfg.par_en && (cfg.mode != 2'd2);
    extra   = use_par || (cfg.mode == 2'd2);
    nd      = use_par ? base_len - CW'(1) : base_len;
    plen    = extra ? nd + CW'(1) : nd;

    par = par_odd;
    for (int i = 0; i < DATA_W; i++) begin
      if (CW'(i) < nd) par = par ^ data[i];
    end

    payload = '0;
    for (int i = 0; i < DATA_W; i++) begin
      if (CW'(i) < nd)                payload[i] = data[i];
      else if (CW'(i) == nd && extra) payload[i] = (cfg.mode == 2'd2) ? bit9 : par;
    end

    frame    = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (CW'(i) < plen) frame[i+1] = payload[i];
    end

    nbits = CW'(1) + plen + (cfg.stop2 ? CW'(2) : CW'(1));
  end
endmodule

// File: rtl/sft_shifter.sv
module sft_shifter #(
  parameter int FW = 12,
  parameter int CW = $clog2(FW + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          tick,
  input  logic [FW-1:0] frame,
  input  logic [CW-1:0] nbits,
  input  logic          sync_mode,
  output logic          busy,
  output logic          done,
  output logic          txd,
  output logic          sclk
);
  logic [FW-2:0] sh;
  logic [CW-1:0] rem;
  logic          sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      txd    <= 1'b1;
      sclk   <= 1'b1;
      sh     <= '1;
      rem    <= '0;
      sync_q <= 1'b0;
    end else begin
      done <= 1'b0;
      sclk <= 1'b1;
      if (!busy) begin
        if (start) begin
          txd    <= frame[0];
          sh     <= frame[FW-1:1];
          rem    <= nbits;
          busy   <= 1'b1;
          sync_q <= sync_mode;
          if (sync_mode) sclk <= 1'b0;
        end
      end else if (tick) begin
        if (rem > CW'(1)) begin
          txd <= sh[0];
          sh  <= {1'b1, sh[FW-2:1]};
          rem <= rem - CW'(1);
          if (sync_q) sclk <= 1'b0;
        end else begin
          busy <= 1'b0;
          done <= 1'b1;
          txd  <= 1'b1;
          rem  <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/sft_top.sv
module sft_top
  import sft_pkg::*;
#(
  parameter int DATA_W = PAY_MAX
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [CFG_W-1:0]  reg_wdata,
  output logic [CFG_W-1:0]  reg_rdata,
  input  logic              baud_tick,
  input  logic              tx_start,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_bit9,
  input  logic              par_odd,
  output logic              tx_busy,
  output logic              tx_done,
  output logic              txd_out,
  output logic              txd_oe,
  output logic              sclk_out,
  output logic              sclk_oe
);
  localparam int FW = DATA_W + 3;
  localparam int CW = $clog2(FW + 1);

  sft_cfg_t      cfg;
  logic [FW-1:0] frame;
  logic [CW-1:0] nbits;

  sft_cfg_reg u_cfg (
    .clk   (clk),
    .rst   (rst),
    .we    (reg_we),
    .wdata (reg_wdata),
    .cfg   (cfg)
  );

  sft_frame_build #(.DATA_W(DATA_W), .FW(FW), .CW(CW)) u_build (
    .cfg     (cfg),
    .data    (tx_data),
    .bit9    (tx_bit9),
    .par_odd (par_odd),
    .frame   (frame),
    .nbits   (nbits)
  );

  sft_shifter #(.FW(FW), .CW(CW)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .start     (tx_start),
    .tick      (baud_tick),
    .frame     (frame),
    .nbits     (nbits),
    .sync_mode (cfg.sync_en),
    .busy      (tx_busy),
    .done      (tx_done),
    .txd       (txd_out),
    .sclk      (sclk_out)
  );

  assign reg_rdata = cfg;
  assign txd_oe    = cfg.dat_oe;
  assign sclk_oe   = cfg.clk_oe;
endmodule

// File: rtl/sft_chk.sv
module sft_chk (
  input logic       clk,
  input logic       rst,
  input logic [7:0] reg_rdata,
  input logic       baud_tick,
  input logic       tx_start,
  input logic       tx_busy,
  input logic       tx_done,
  input logic       txd_out,
  input logic       txd_oe,
  input logic       sclk_out,
  input logic       sclk_oe
);
  // R8
  done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
    tx_done |-> (!tx_busy && $past(tx_busy)));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    tx_done |=> !tx_done);
  // R8
  accept_chk: assert property (@(posedge clk) disable iff (rst)
    (!tx_busy && tx_start) |=> tx_busy);
  // R9
  hold_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_busy && !baud_tick) |=> tx_busy);
  // R3
  idle_high_chk: assert property (@(posedge clk) disable iff (rst)
    !tx_busy |-> txd_out);
  // R12
  sclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !tx_busy |-> sclk_out);
  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rdata & 8'h08) == 8'h00);
  // R11
  oe_track_chk: assert property (@(posedge clk) disable iff (rst)
    (txd_oe == reg_rdata[0]) && (sclk_oe == reg_rdata[1]));
endmodule

bind sft_top sft_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_rdata (reg_rdata),
  .baud_tick (baud_tick),
  .tx_start  (tx_start),
  .tx_busy   (tx_busy),
  .tx_done   (tx_done),
  .txd_out   (txd_out),
  .txd_oe    (txd_oe),
  .sclk_out  (sclk_out),
  .sclk_oe   (sclk_oe)
);

// File: tb/sft_top_test.sv
module sft_top_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       baud_tick = 1'b0;
  logic       tx_start = 1'b0;
  logic [8:0] tx_data = '0;
  logic       tx_bit9 = 1'b0;
  logic       par_odd = 1'b0;
  logic       tx_busy, tx_done, txd_out, txd_oe, sclk_out, sclk_oe;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sft_top uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .baud_tick(baud_tick), .tx_start(tx_start),
    .tx_data(tx_data), .tx_bit9(tx_bit9), .par_odd(par_odd),
    .tx_busy(tx_busy), .tx_done(tx_done), .txd_out(txd_out),
    .txd_oe(txd_oe), .sclk_out(sclk_out), .sclk_oe(sclk_oe)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int pay_len(logic [7:0] c);
    case (c[5:4])
      2'd0: return 7;
      2'd1: return 8;
      default: return 9;
    endcase
  endfunction

  function automatic int exp_len(logic [7:0] c);
    return 1 + pay_len(c) + (c[6] ? 2 : 1);
  endfunction

  function automatic logic exp_bit(logic [7:0] c, logic [8:0] d, logic b9,
                                   logic odd, int k);
    int pl = pay_len(c);
    int j = k - 1;
    int ones = 0;
    if (k == 0) return 1'b0;
    if (j >= pl) return 1'b1;
    if (c[5:4] == 2'd2) return (j < 8) ? d[j] : b9;
    if (!c[7]) return d[j];
    if (j < pl - 1) return d[j];
    for (int i = 0; i < pl - 1; i++) ones += int'(d[i]);
    return logic'(ones % 2) ^ odd;
  endfunction

  task automatic write_cfg(logic [7:0] v);
    @(negedge clk);
    reg_we = 1'b1;
    reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0;
    check("R2 readback", reg_rdata, v & 8'hF7);
    check("R11 txd_oe", txd_oe, v[0]);
    check("R11 sclk_oe", sclk_oe, v[1]);
  endtask

  // opt[0]: tick together with start (R13); opt[1]: start while busy (R9)
  // opt[2]: start on final tick (R9); opt[3]: write mid frame (R10)
  task automatic send_frame(logic [7:0] c, logic [8:0] d, logic b9, logic odd,
                            logic [3:0] opt, logic [7:0] midv);
    int n = exp_len(c);
    @(negedge clk);
    tx_data = d;
    tx_bit9 = b9;
    par_odd = odd;
    tx_start = 1'b1;
    baud_tick = opt[0];
    @(negedge clk);
    tx_start = 1'b0;
    baud_tick = 1'b0;
    tx_data = ~d;
    tx_bit9 = ~b9;
    for (int k = 0; k < n; k++) begin
      check($sformatf("R3 R4 R5 R6 R7 bit %0d", k), txd_out, exp_bit(c, d, b9, odd, k));
      check("R8 busy", tx_busy, 1'b1);
      check("R12 sclk low", sclk_out, c[2] ? 1'b0 : 1'b1);
      if (k == 1 && opt[3]) begin reg_we = 1'b1; reg_wdata = midv; end
      if (k == 3 && opt[1]) tx_start = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
      tx_start = 1'b0;
      check("R12 sclk high", sclk_out, 1'b1);
      baud_tick = 1'b1;
      if (k == n - 1 && opt[2]) tx_start = 1'b1;
      @(negedge clk);
      baud_tick = 1'b0;
      tx_start = 1'b0;
    end
    check("R8 done", tx_done, 1'b1);
    check("R8 busy low", tx_busy, 1'b0);
    check("R3 idle", txd_out, 1'b1);
    @(negedge clk);
    check("R8 done pulse", tx_done, 1'b0);
    check("R9 no restart", tx_busy, 1'b0);
    check("R9 line idle", txd_out, 1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] c;
    logic [7:0] c2;
    logic [8:0] d;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 rdata", reg_rdata, 8'h00);
    check("R1 txd", txd_out, 1'b1);
    check("R1 sclk", sclk_out, 1'b1);
    check("R1 busy", tx_busy, 1'b0);
    check("R1 done", tx_done, 1'b0);
    check("R1 oe", {txd_oe, sclk_oe}, 2'b00);

    // R13: idle tick has no effect
    baud_tick = 1'b1;
    @(negedge clk);
    baud_tick = 1'b0;
    check("R13 idle tick busy", tx_busy, 1'b0);
    check("R13 idle tick line", txd_out, 1'b1);

    // R2: unused bit reads zero
    write_cfg(8'hFF);

    // directed: all modes, parity, stop lengths, both parities
    for (int m = 0; m < 4; m++) begin
      for (int p = 0; p < 2; p++) begin
        for (int s = 0; s < 2; s++) begin
          c = {p[0], s[0], m[1:0], 4'b0101};
          write_cfg(c);
          send_frame(c, 9'h1A5, 1'b1, 1'b0, 4'h0, 8'h00);
          send_frame(c, 9'h0B3, 1'b0, 1'b1, 4'h0, 8'h00);
        end
      end
    end

    // R12 synchronous shift clock
    c = 8'h37;
    write_cfg(c);
    send_frame(c, 9'h155, 1'b1, 1'b0, 4'h0, 8'h00);

    // R10: write mid frame, next frame uses new value
    c = 8'h01;
    c2 = 8'hF0;
    write_cfg(c);
    send_frame(c, 9'h0F0, 1'b0, 1'b0, 4'b1000, c2);
    check("R10 mid write visible", reg_rdata, c2);
    send_frame(c2, 9'h0F0, 1'b0, 1'b0, 4'h0, 8'h00);

    // R10: write in the start cycle applies to the next frame
    c = 8'h10;
    write_cfg(c);
    @(negedge clk);
    reg_we = 1'b1;
    reg_wdata = 8'hF0;
    tx_data = 9'h1FF;
    tx_bit9 = 1'b0;
    par_odd = 1'b0;
    tx_start = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
    tx_start = 1'b0;
    for (int k = 0; k < exp_len(c); k++) begin
      check("R10 start-cycle write", txd_out, exp_bit(c, 9'h1FF, 1'b0, 1'b0, k));
      baud_tick = 1'b1;
      @(negedge clk);
      baud_tick = 1'b0;
    end
    check("R10 old frame ends", tx_done, 1'b1);

    // random frames with same-cycle corner options
    for (int r = 0; r < 40; r++) begin
      c = 8'($urandom);
      d = 9'($urandom);
      write_cfg(c);
      send_frame(c, d, 1'($urandom), 1'($urandom), 4'($urandom) & 4'b0111, 8'h00);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule